// File: doc/BRIEF.md
# Configurable Registered Address/Command Buffer

The block is a bank of flip-flops between an address/command source and many loads. On each rising clock edge it captures its data inputs and drives them from flops. A static width input picks between two arrangements. In the straight arrangement, 25 inputs map to 25 outputs. In the fan-out arrangement, 14 inputs each drive two output copies on a 28-bit output bus. A second static input picks where the two copies of each bit sit.

Two select inputs gate the register. When both are high, the outputs hold their last value. When either is low, the outputs follow the inputs each clock, so tying one select low gives a plain register. An active-low reset acts at once, without a clock. It clears every flop and takes priority over the gating. The configuration inputs change only while reset is held.

A small control machine decides what each clock edge does. Its states are:

- `ST_CLEAR`: entered by reset; no edge has been taken since.
- `ST_LOAD`: the last edge captured new data.
- `ST_HOLD`: the last edge kept the old data.

Its transitions are the same from every state. An edge with both selects high (`hold_edge`) goes to `ST_HOLD`. Any other edge (`load_edge`) goes to `ST_LOAD`. Reset low (`async_clear`) returns to `ST_CLEAR`.

Top module: `acb_regbuf`

## Requirements
- R1: With `fan_mode`=0, after a loading edge `q_out[24:0]` equals `d_in[24:0]` at that edge, and `q_out[27:25]` is 0.
- R2: With `fan_mode`=1 and `map_b`=0, after a loading edge both `q_out[2i]` and `q_out[2i+1]` equal `d_in[i]` for i = 0..13.
- R3: With `fan_mode`=1 and `map_b`=1, after a loading edge both `q_out[i]` and `q_out[i+14]` equal `d_in[i]` for i = 0..13.
- R4: With `fan_mode`=1, `d_in[24:14]` has no effect on any output.
- R5: An edge at which `sel_a` and `sel_b` are both 1 leaves `q_out` unchanged.
- R6: An edge at which `sel_a` or `sel_b` is 0 loads new data. With one select tied to 0, every edge loads.
- R7: While `rst_n` is 0, `q_out` is all zero. This takes effect without a clock edge, overrides the select gating, and holds through clock edges taken in reset.
- R8: After `rst_n` rises, `q_out` stays all zero for as long as `d_in` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| fan_mode | input | 1 | 0: 25-bit straight, 1: 14-bit two-copy (static) |
| map_b | input | 1 | Copy placement in two-copy mode: 0 adjacent pairs, 1 halves (static) |
| sel_a | input | 1 | Gating select; hold only when both selects are 1 |
| sel_b | input | 1 | Gating select; hold only when both selects are 1 |
| d_in | input | 25 | Address/command inputs |
| q_out | output | 28 | Registered outputs |

## Verification
Every data result appears after exactly one flop. The bench changes inputs on a falling edge, and the result is due just after the next rising edge. The bench samples each result a quarter period after that edge. A held edge (R5) is due at the same edge and is compared with the value the model kept, not with the new input. The effect of reset (R7) is due with no edge at all, so it is checked one time step after `rst_n` falls. Clock edges taken while reset is held are checked as well. The outputs after release (R8) are checked edge by edge while the inputs stay zero.

// File: rtl/acb_pkg.sv
package acb_pkg;
    localparam int ACB_WIDE   = 25;
    localparam int ACB_NARROW = 14;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_LOAD  = 2'd1,
        ST_HOLD  = 2'd2
    } acb_state_e;
endpackage

// File: rtl/acb_ctrl.sv
module acb_ctrl
    import acb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_a,
    input  logic       sel_b,
    output logic       load_en,
    output acb_state_e cur_state
);
    acb_state_e state_q;
    acb_state_e state_d;

    // next-state decision for the coming edge
    always_comb begin
        unique case (state_q)
            ST_CLEAR, ST_LOAD, ST_HOLD: begin
                if (sel_a && sel_b) state_d = ST_HOLD;   // hold_edge
                else                state_d = ST_LOAD;   // load_edge
            end
            default: state_d = ST_CLEAR;
        endcase
    end

    // state register; async_clear returns to ST_CLEAR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        load_en   = (state_d == ST_LOAD);
        cur_state = state_q;
    end
endmodule

// File: rtl/acb_fanout.sv
module acb_fanout #(
    parameter int WIDE   = 25,
    parameter int NARROW = 14,
    localparam int OUTW  = 2 * NARROW
) (
    input  logic [WIDE-1:0] d,
    input  logic            fan_mode,
    input  logic            map_b,
    output logic [OUTW-1:0] mapped
);
    logic [OUTW-1:0] adj_v;
    logic [OUTW-1:0] half_v;
    logic [OUTW-1:0] flat_v;

    for (genvar i = 0; i < NARROW; i++) begin : g_pair
        assign adj_v[2*i]        = d[i];
        assign adj_v[2*i+1]      = d[i];
        assign half_v[i]         = d[i];
        assign half_v[i+NARROW]  = d[i];
    end

    for (genvar j = 0; j < OUTW; j++) begin : g_flat
        if (j < WIDE) begin : g_used
            assign flat_v[j] = d[j];
        end else begin : g_zero
            assign flat_v[j] = 1'b0;
        end
    end

    always_comb begin
        if (!fan_mode)  mapped = flat_v;
        else if (map_b) mapped = half_v;
        else            mapped = adj_v;
    end
endmodule

// File: rtl/acb_capture.sv
module acb_capture #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         sel_a,
    input  logic         sel_b,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= nxt;
    end

    // An open select at the edge loads the mapped word seen at that edge.
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sel_a && sel_b)) |=> (q == $past(nxt)));
endmodule

// File: rtl/acb_regbuf.sv
module acb_regbuf
    import acb_pkg::*;
#(
    parameter int WIDE   = ACB_WIDE,
    parameter int NARROW = ACB_NARROW,
    localparam int OUTW  = 2 * NARROW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fan_mode,
    input  logic            map_b,
    input  logic            sel_a,
    input  logic            sel_b,
    input  logic [WIDE-1:0] d_in,
    output logic [OUTW-1:0] q_out
);
    logic            load_en;
    acb_state_e      cur_state;
    logic [OUTW-1:0] mapped;

    acb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .load_en   (load_en),
        .cur_state (cur_state)
    );

    acb_fanout #(.WIDE(WIDE), .NARROW(NARROW)) u_fanout (
        .d        (d_in),
        .fan_mode (fan_mode),
        .map_b    (map_b),
        .mapped   (mapped)
    );

    acb_capture #(.W(OUTW)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .nxt     (mapped),
        .q       (q_out)
    );

    localparam logic [OUTW-1:0] EVEN_MASK = {NARROW{2'b01}};

    // R1: bits beyond the straight width stay low
    assert_spare_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fan_mode) |-> (q_out[OUTW-1:WIDE] == '0));

    // R2: adjacent pairs carry identical copies
    assert_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fan_mode && !map_b) |-> ((q_out & EVEN_MASK) == ((q_out >> 1) & EVEN_MASK)));

    // R3: upper half mirrors lower half
    assert_halves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fan_mode && map_b) |-> (q_out[OUTW-1:NARROW] == q_out[NARROW-1:0]));

    // R5: an edge recorded as held changed nothing
    assert_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_HOLD) |-> (q_out == $past(q_out)));

    // R7: reset low means zero outputs at every edge
    assert_reset_low_R7: assert property (@(posedge clk)
        (!rst_n) |-> (q_out == '0));
endmodule

// File: tb/test_acb_regbuf.sv
module test_acb_regbuf;
    localparam int CLK_PER = 10;
    localparam int WIDE = 25;
    localparam int NARROW = 14;
    localparam int OUTW = 28;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fan_mode = 1'b0;
    logic            map_b = 1'b0;
    logic            sel_a = 1'b0;
    logic            sel_b = 1'b0;
    logic [WIDE-1:0] d_in = '0;
    logic [OUTW-1:0] q_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [OUTW-1:0] exp_q[$];
    string           tag_q[$];
    logic [OUTW-1:0] model_q = '0;

    acb_regbuf i_acb_regbuf (
        .clk(clk), .rst_n(rst_n), .fan_mode(fan_mode), .map_b(map_b),
        .sel_a(sel_a), .sel_b(sel_b), .d_in(d_in), .q_out(q_out)
    );

    always #(CLK_PER/2) clk = ~clk;

    function automatic logic [OUTW-1:0] model_map(logic fm, logic mb, logic [WIDE-1:0] d);
        logic [OUTW-1:0] r = '0;
        if (!fm) begin
            for (int k = 0; k < WIDE; k++) r[k] = d[k];
        end else begin
            for (int k = 0; k < NARROW; k++) begin
                if (mb) begin r[k] = d[k]; r[k+NARROW] = d[k]; end
                else    begin r[2*k] = d[k]; r[2*k+1] = d[k]; end
            end
        end
        return r;
    endfunction

    task automatic check(logic [OUTW-1:0] act, logic [OUTW-1:0] exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: apply at falling edge, push result due after next rising edge
    task automatic drive(logic [WIDE-1:0] d, logic sa, logic sb, string tag);
        @(negedge clk);
        d_in = d; sel_a = sa; sel_b = sb;
        if (!(sa && sb)) model_q = model_map(fan_mode, map_b, d);
        exp_q.push_back(model_q);
        tag_q.push_back(tag);
    endtask

    // monitor: a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PER/4);
            if (exp_q.size() > 0) check(q_out, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic enter_reset(logic fm, logic mb);
        wait (exp_q.size() == 0);
        @(negedge clk);
        #(CLK_PER/4);
        rst_n = 1'b0;
        #1;
        check(q_out, '0, "R7 async clear");
        model_q = '0;
        fan_mode = fm; map_b = mb;
        @(negedge clk);
        d_in = '1; sel_a = 1'b0; sel_b = 1'b0;
        @(posedge clk);
        #(CLK_PER/4);
        check(q_out, '0, "R7 edge in reset");
        @(negedge clk);
        d_in = '0;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PER * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        #1;
        check(q_out, '0, "R7 reset state");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R8: low data after release keeps outputs low
        for (int n = 0; n < 3; n++) drive('0, 1'b0, 1'b1, "R8");

        // R1 straight mode, R6 either select low
        drive(25'h1ABCDEF, 1'b0, 1'b1, "R1");
        drive(25'h1FFFFFF, 1'b1, 1'b0, "R1 spare bits low");
        drive(25'h0A5A5A5, 1'b0, 1'b0, "R6");
        // R5 hold with both selects high
        drive(25'h1234567, 1'b1, 1'b1, "R5");
        drive(25'h0000001, 1'b1, 1'b1, "R5");
        drive(25'h0F0F0F0, 1'b0, 1'b1, "R6 release");

        // R7 reset overrides gating
        drive(25'h1555555, 1'b1, 1'b1, "R5 before reset");
        enter_reset(1'b1, 1'b0);
        for (int n = 0; n < 2; n++) drive('0, 1'b1, 1'b0, "R8");

        // R2 adjacent copies, R4 upper inputs ignored
        drive(25'h0002A5B, 1'b0, 1'b1, "R2");
        drive(25'h1FFC000, 1'b0, 1'b0, "R4 upper only");
        drive(25'h1FF3FFF, 1'b1, 1'b0, "R2 R4");
        drive(25'h0001234, 1'b1, 1'b1, "R5 fan mode");

        // R3 half placement
        enter_reset(1'b1, 1'b1);
        drive(25'h0003C71, 1'b0, 1'b1, "R3");
        drive(25'h1FFC000, 1'b0, 1'b1, "R4 upper only");
        drive(25'h0002001, 1'b1, 1'b0, "R3");

        // R6 plain register with sel_b tied low
        enter_reset(1'b0, 1'b0);
        for (int n = 0; n < 6; n++)
            drive(25'(32'h00B1C3 * (n + 7)), n[0], 1'b0, "R6 tied low");

        wait (exp_q.size() == 0);
        @(negedge clk);
        finish_run();
    end
endmodule